// File: doc/BRIEF.md
# Converter Power and Clock Mode Manager

This block keeps the power state and the conversion clock source of a successive-approximation converter. Every accepted control byte carries a two-bit power field. Two of its codes pick the normal state and a clock source: external, or the internal oscillator. The other two codes ask for a standby or a full power-down. A power-down request is held back until the conversion in flight is finished. The next write strobe brings the converter back to the normal state. The power-down codes never touch the stored clock choice.

An active-low shutdown pin overrides everything. It forces full power-down in the same cycle and raises an abort request toward the conversion sequencer if a conversion is running. The block drives three enables: the internal oscillator, the reference buffer and the bandgap. The analog parts behind these enables are outside the block. The result readout path is not gated by any power state.

Top module: `pwr_clk_mode_mgr`

## Requirements
- R1: While reset is asserted, and after it is released, the state is normal with the external clock. That is: mode_o = 0, int_clk_o = 0, osc_en_o = 0, refbuf_en_o = 1, bandgap_en_o = 1, abort_o = 0.
- R2: The power field is ctrl_i[7:6]. A commit with field 00 or 01 stores ctrl_i[6] as the clock source (1 = internal), visible on int_clk_o after the edge. In the normal state osc_en_o equals int_clk_o.
- R3: A commit with field 10 or 11 leaves int_clk_o unchanged.
- R4: Field 10 requests standby (mode_o = 1) and field 11 requests full power-down (mode_o = 2). The request is held and applied on the first clock edge after the commit at which conv_active_i is low. Before that, mode_o stays 0.
- R5: A wr_start_i pulse with shdn_n_i high returns the stored state to normal (mode_o = 0) at the next edge. The same pulse discards a held power-down request. The pulse takes priority over a held request that would be applied at the same edge.
- R6: In standby, bandgap_en_o and refbuf_en_o are 1 and osc_en_o is 0. In full power-down, only bandgap_en_o is 1.
- R7: While shdn_n_i is low, in the same cycle, mode_o = 2, refbuf_en_o = 0 and osc_en_o = 0, and abort_o follows conv_active_i.
- R8: While shdn_n_i is low, wr_start_i and wr_commit_i have no effect. After release, the state is normal with the clock source that was stored before shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_start_i | input | 1 | One-cycle pulse at the start of a write (strobe falling edge) |
| wr_commit_i | input | 1 | One-cycle pulse when a control byte is accepted |
| ctrl_i | input | 8 | Control byte; power field at bits [7:6] |
| conv_active_i | input | 1 | Conversion sequence in progress |
| shdn_n_i | input | 1 | Shutdown pin, active low, already synchronized |
| mode_o | output | 2 | Effective power state: 0 normal, 1 standby, 2 full |
| int_clk_o | output | 1 | Stored clock source, 1 = internal oscillator |
| osc_en_o | output | 1 | Internal oscillator enable |
| refbuf_en_o | output | 1 | Reference buffer enable |
| bandgap_en_o | output | 1 | Bandgap enable |
| abort_o | output | 1 | Request to abort the running conversion |

## Verification
Two pairs of events can land in the same cycle. The first pair is a held power-down request becoming due and a new write start. The bench holds a standby request with the conversion idle and pulses wr_start_i at the edge where the request would apply. It then expects mode_o to stay 0 at that edge and at the following one. The second pair is shutdown and a running conversion: shdn_n_i falls while conv_active_i is high. The bench expects mode_o = 2, abort_o = 1 and the buffer and oscillator disabled after that edge, and expects a write start under shutdown to be ignored.

// File: rtl/pwr_mgr_pkg.sv
package pwr_mgr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_FULL    = 2'd2
  } pwr_mode_e;
endpackage

// File: rtl/pwr_clk_src.sv
module pwr_clk_src #(
  parameter int CTRL_W = 8,
  parameter int PD_LSB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              hold_i,
  output logic              int_clk_o
);
  localparam int PD_MSB = PD_LSB + 1;

  logic int_clk_q;
  logic int_clk_d;
  logic int_clk_en;

  // Only the two normal-operation codes carry a clock choice.
  always_comb begin
    int_clk_en = commit_i && !hold_i && !ctrl_i[PD_MSB];
    int_clk_d  = ctrl_i[PD_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_clk_q <= 1'b0;
    end else if (int_clk_en) begin
      int_clk_q <= int_clk_d;
    end
  end

  assign int_clk_o = int_clk_q;

  assert_pd_keeps_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && ctrl_i[PD_MSB]) |=> $stable(int_clk_o));

  assert_shdn_keeps_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(int_clk_o));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mgr_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int PD_LSB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_i,
  input  logic              commit_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              conv_active_i,
  input  logic              hold_i,
  output pwr_mode_e         mode_o
);
  localparam int PD_MSB = PD_LSB + 1;

  pwr_mode_e mode_q, mode_d;
  logic      pend_q, pend_d;
  logic      pfull_q, pfull_d;

  always_comb begin
    mode_d  = mode_q;
    pend_d  = pend_q;
    pfull_d = pfull_q;
    if (hold_i) begin
      // Shutdown pin dominates; stored state returns to normal for release.
      mode_d = MODE_NORMAL;
      pend_d = 1'b0;
    end else if (wake_i) begin
      mode_d = MODE_NORMAL;
      pend_d = 1'b0;
    end else begin
      if (pend_q && !conv_active_i) begin
        mode_d = pfull_q ? MODE_FULL : MODE_STANDBY;
        pend_d = 1'b0;
      end
      if (commit_i) begin
        pend_d  = ctrl_i[PD_MSB];
        pfull_d = ctrl_i[PD_LSB];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_NORMAL;
      pend_q  <= 1'b0;
      pfull_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      pend_q  <= pend_d;
      pfull_q <= pfull_d;
    end
  end

  assign mode_o = mode_q;

  assert_defer_pd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_NORMAL && $past(mode_q) == MODE_NORMAL) |-> $past(!conv_active_i));

  assert_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_i && !hold_i) |=> (mode_q == MODE_NORMAL));

  assert_hold_resets_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (mode_q == MODE_NORMAL));
endmodule

// File: rtl/pwr_enable_map.sv
module pwr_enable_map
  import pwr_mgr_pkg::*;
(
  input  pwr_mode_e mode_i,
  input  logic      int_clk_i,
  output logic      osc_en_o,
  output logic      refbuf_en_o,
  output logic      bandgap_en_o
);
  always_comb begin
    osc_en_o     = 1'b0;
    refbuf_en_o  = 1'b0;
    bandgap_en_o = 1'b1;
    unique case (mode_i)
      MODE_NORMAL: begin
        osc_en_o    = int_clk_i;
        refbuf_en_o = 1'b1;
      end
      MODE_STANDBY: begin
        refbuf_en_o = 1'b1;
      end
      default: begin
        refbuf_en_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pwr_clk_mode_mgr.sv
module pwr_clk_mode_mgr
  import pwr_mgr_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int PD_LSB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start_i,
  input  logic              wr_commit_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              conv_active_i,
  input  logic              shdn_n_i,
  output logic [1:0]        mode_o,
  output logic              int_clk_o,
  output logic              osc_en_o,
  output logic              refbuf_en_o,
  output logic              bandgap_en_o,
  output logic              abort_o
);
  logic      hold;
  pwr_mode_e stored_mode;
  pwr_mode_e eff_mode;
  logic      int_clk;

  assign hold = !shdn_n_i;

  pwr_clk_src #(.CTRL_W(CTRL_W), .PD_LSB(PD_LSB)) clk_src_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (wr_commit_i),
    .ctrl_i    (ctrl_i),
    .hold_i    (hold),
    .int_clk_o (int_clk)
  );

  pwr_mode_seq #(.CTRL_W(CTRL_W), .PD_LSB(PD_LSB)) mode_seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wake_i        (wr_start_i),
    .commit_i      (wr_commit_i),
    .ctrl_i        (ctrl_i),
    .conv_active_i (conv_active_i),
    .hold_i        (hold),
    .mode_o        (stored_mode)
  );

  // Hardware shutdown acts without waiting for a clock edge.
  assign eff_mode = hold ? MODE_FULL : stored_mode;

  pwr_enable_map enable_map_i (
    .mode_i       (eff_mode),
    .int_clk_i    (int_clk),
    .osc_en_o     (osc_en_o),
    .refbuf_en_o  (refbuf_en_o),
    .bandgap_en_o (bandgap_en_o)
  );

  assign mode_o    = eff_mode;
  assign int_clk_o = int_clk;
  assign abort_o   = hold && conv_active_i;

  assert_shdn_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_i |-> (mode_o == 2'd2 && !refbuf_en_o && !osc_en_o));

  assert_standby_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |-> (refbuf_en_o && bandgap_en_o && !osc_en_o));

  assert_full_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (bandgap_en_o && !refbuf_en_o && !osc_en_o));

  assert_osc_follows_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (osc_en_o == int_clk_o));
endmodule

// File: tb/pwr_clk_mode_mgr_tb_top.sv
module pwr_clk_mode_mgr_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_start_i;
  logic       wr_commit_i;
  logic [7:0] ctrl_i;
  logic       conv_active_i;
  logic       shdn_n_i;
  logic [1:0] mode_o;
  logic       int_clk_o, osc_en_o, refbuf_en_o, bandgap_en_o, abort_o;

  int checks = 0;
  int errors = 0;

  pwr_clk_mode_mgr dut_i (
    .clk(clk), .rst_n(rst_n), .wr_start_i(wr_start_i), .wr_commit_i(wr_commit_i),
    .ctrl_i(ctrl_i), .conv_active_i(conv_active_i), .shdn_n_i(shdn_n_i),
    .mode_o(mode_o), .int_clk_o(int_clk_o), .osc_en_o(osc_en_o),
    .refbuf_en_o(refbuf_en_o), .bandgap_en_o(bandgap_en_o), .abort_o(abort_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Row: ws wc pd[1:0] conv shn | mode[1:0] ci osc ref bg abort
  localparam int NROWS = 16;
  localparam logic [12:0] ROWS [NROWS] = '{
    13'b0_1_01_0_1_00_1_1_1_1_0,  // R2 select internal clock
    13'b0_0_00_1_1_00_1_1_1_1_0,  // R2 hold
    13'b0_1_10_1_1_00_1_1_1_1_0,  // R4 standby request during conversion
    13'b0_0_00_1_1_00_1_1_1_1_0,  // R4 still deferred
    13'b0_0_00_0_1_01_1_0_1_1_0,  // R4 R6 standby applied, clock kept
    13'b1_0_00_0_1_00_1_1_1_1_0,  // R5 wake
    13'b0_1_11_0_1_00_1_1_1_1_0,  // R4 full request, conv idle
    13'b0_0_00_0_1_10_1_0_0_1_0,  // R4 R6 full applied
    13'b1_0_00_0_1_00_1_1_1_1_0,  // R5 wake from full
    13'b0_1_00_0_1_00_0_0_1_1_0,  // R2 back to external clock
    13'b0_1_10_0_1_00_0_0_1_1_0,  // R4 standby request held
    13'b1_0_00_0_1_00_0_0_1_1_0,  // R5 wake collides with due request
    13'b0_0_00_0_1_00_0_0_1_1_0,  // R5 request discarded
    13'b0_0_00_1_0_10_0_0_0_1_1,  // R7 shutdown with conversion running
    13'b1_0_00_0_0_10_0_0_0_1_0,  // R8 write start ignored
    13'b0_0_00_0_1_00_0_0_1_1_0   // R8 release to normal
  };

  function automatic string row_req(int i);
    case (i)
      0, 1, 9:        return "R2";
      2, 3, 6, 10:    return "R4";
      4, 7:           return "R6";
      5, 8, 11, 12:   return "R5";
      13:             return "R7";
      default:        return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic ws, logic wc, logic [1:0] pd, logic conv, logic shn);
    wr_start_i    = ws;
    wr_commit_i   = wc;
    ctrl_i        = {pd, 6'b101010};
    conv_active_i = conv;
    shdn_n_i      = shn;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk_all(string req, logic [1:0] m, logic ci, logic osc, logic rf, logic bg, logic ab);
    chk(req, "mode_o", mode_o, m);
    chk(req, "int_clk_o", {1'b0, int_clk_o}, {1'b0, ci});
    chk(req, "osc_en_o", {1'b0, osc_en_o}, {1'b0, osc});
    chk(req, "refbuf_en_o", {1'b0, refbuf_en_o}, {1'b0, rf});
    chk(req, "bandgap_en_o", {1'b0, bandgap_en_o}, {1'b0, bg});
    chk(req, "abort_o", {1'b0, abort_o}, {1'b0, ab});
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 2'b00, 0, 1);
    repeat (3) tick();
    chk_all("R1", 2'd0, 0, 0, 1, 1, 0);   // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk_all("R1", 2'd0, 0, 0, 1, 1, 0);   // R1 after release

    for (int i = 0; i < NROWS; i++) begin
      drive(ROWS[i][12], ROWS[i][11], ROWS[i][10:9], ROWS[i][8], ROWS[i][7]);
      tick();
      chk_all(row_req(i), ROWS[i][6:5], ROWS[i][4], ROWS[i][3], ROWS[i][2], ROWS[i][1], ROWS[i][0]);
    end

    // R8: a clock choice written under shutdown is dropped
    drive(0, 1, 2'b01, 0, 0);
    tick();
    drive(0, 0, 2'b00, 0, 0);
    tick();
    drive(0, 0, 2'b00, 0, 1);
    tick();
    chk_all("R8", 2'd0, 0, 0, 1, 1, 0);

    // R3: full power-down code keeps the internal clock choice
    drive(0, 1, 2'b01, 0, 1);
    tick();
    drive(0, 1, 2'b11, 1, 1);
    tick();
    chk_all("R3", 2'd0, 1, 1, 1, 1, 0);
    drive(0, 0, 2'b00, 0, 1);
    tick();
    chk_all("R6", 2'd2, 1, 0, 0, 1, 0);
    drive(1, 0, 2'b00, 0, 1);
    tick();
    chk_all("R5", 2'd0, 1, 1, 1, 1, 0);

    // R1: reset in the middle of standby
    drive(0, 1, 2'b10, 0, 1);
    tick();
    drive(0, 0, 2'b00, 0, 1);
    tick();
    chk_all("R4", 2'd1, 1, 0, 1, 1, 0);
    rst_n = 1'b0;
    #1;
    chk_all("R1", 2'd0, 0, 0, 1, 1, 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk_all("R1", 2'd0, 0, 0, 1, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule